// File: doc/BRIEF.md
# Serial DAC Front End

This block is the digital side of a serial-input digital-to-analog converter. A host frames a 16-bit word with an active-low frame strobe and shifts it in, most significant bit first, on the falling edges of a serial clock. The data field of that word is moved into the DAC holding register in one of two ways. If the load strobe is low when the frame opens, the move happens when the frame closes. If the load strobe is high at that moment, the word is parked, and the move happens once the load strobe is later driven low.

All serial and control inputs are asynchronous to the block's own system clock. Each passes through a two-flop synchronizer, and the logic acts on the edges it detects there. The same shift register also serves two other jobs. It passes written data on to a downstream converter in a daisy chain, delayed by 16 serial clocks. It also unloads the holding register when the host asks for a readback. The serial output is open drain, so it appears here as a pull-low enable. A clear input forces the analog side to its reset level without disturbing any register, and a power-down input is passed on as a flag.

Top module: `serdac_front`

## Requirements
- R1: After reset, `dac_code_o` is 0, `out_clear_o` and `pwrdn_o` are 0, and `sdo_pull_o` is 0 (line released). The shift register and the parked-update flag are also cleared.
- R2: A frame captures one bit on each serial clock falling edge while the frame strobe is low, MSB first. With CODE_W=14 the code is word bits 13..0, and bits 15..14 are ignored. With CODE_W=12 the code is word bits 13..2, and bits 15, 14, 1 and 0 are ignored.
- R3: If the load strobe is low when the frame strobe falls, a complete frame writes the holding register a few system clocks after the frame strobe rises.
- R4: If the load strobe is high when the frame strobe falls, the rise of the frame strobe leaves the holding register unchanged. The parked code is written once the load strobe is seen low, and a second load pulse with nothing parked changes nothing.
- R5: A frame that closes after fewer than 16 falling edges is dropped. It neither writes the holding register nor parks a code for a later load pulse.
- R6: Without readback, each bit presented on `sdin_i` appears on the serial output 16 falling edges later, and the output changes only after falling edges. `sdo_pull_o`=1 means the line is pulled low (bit 0); 0 means released (bit 1).
- R7: After the readback enable goes low, the next falling edge loads {2'b00, code left-justified in 14 bits} into the shift register and presents its bit 15. Each further falling edge presents the next lower bit. Readback leaves the holding register unchanged.
- R8: A falling edge on the clear input sets `out_clear_o` and leaves the holding register as it is. `out_clear_o` drops once the clear input is high and the load strobe is low, whether the load strobe was already low or is pulsed later.
- R9: `pwrdn_o` follows the power-down input after synchronization and has no effect on `dac_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| frame_n_i | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low load strobe |
| rdbk_n_i | input | 1 | Active-low readback enable |
| clr_n_i | input | 1 | Active-low output clear |
| pwrdn_i | input | 1 | Power-down request, active high |
| dac_code_o | output | CODE_W | Holding register contents, straight binary |
| out_clear_o | output | 1 | Output forced to its reset level |
| pwrdn_o | output | 1 | Power-down flag |
| sdo_pull_o | output | 1 | Open-drain serial output pull-low enable |

## Verification
A wrong bit counter shows at the frame's close: a short frame lands in the holding register, or a full frame does not, within about five system clocks of the frame strobe rising. A wrong deferred-mode flag shows as a code that moves on the frame rise when it should wait for the load strobe. A stale parked flag shows as a second load pulse that moves the code again. Errors in the shift path only reach the ports through the serial output. They show 16 falling edges later in daisy-chain mode, or across the 16 readback edges, so the bench rebuilds whole words from the serial output and compares them.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W = 16;
  localparam int FIELD_W = 14;

  // Data field of a received word, right-justified for a code_w-bit converter.
  function automatic logic [FIELD_W-1:0] word_to_code(logic [WORD_W-1:0] w, int code_w);
    logic [FIELD_W-1:0] f;
    f = w[FIELD_W-1:0];
    return f >> (FIELD_W - code_w);
  endfunction

  // Word placed in the shift register for readback: top two bits zero.
  function automatic logic [WORD_W-1:0] code_to_word(logic [FIELD_W-1:0] c, int code_w);
    logic [FIELD_W-1:0] f;
    f = c << (FIELD_W - code_w);
    return {2'b00, f};
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
        prev_q[i] <= RST_VAL[i];
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
        prev_q[i] <= s2_q;
      end
    end
    assign lvl_o[i]  = s2_q;
    assign fall_o[i] = prev_q[i] & ~s2_q;
    assign rise_o[i] = ~prev_q[i] & s2_q;
  end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_fall,
  input  logic              frame_start,
  input  logic              frame_low,
  input  logic              rb_low,
  input  logic              rb_fall,
  input  logic              sdin,
  input  logic [WORD_W-1:0] rb_word,
  output logic [WORD_W-1:0] shift_o,
  output logic              full_o,
  output logic              sdo_o,
  output logic              rb_load_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q, arm_q;

  assign full_o    = (cnt_q == CNT_W'(WORD_W));
  assign rb_load_o = sclk_fall & arm_q & rb_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      sdo_q   <= 1'b1;
      arm_q   <= 1'b0;
    end else begin
      if (rb_load_o) begin
        shift_q <= {rb_word[WORD_W-2:0], 1'b0};
        sdo_q   <= rb_word[WORD_W-1];
        arm_q   <= 1'b0;
      end else begin
        if (rb_fall) arm_q <= 1'b1;
        else if (!rb_low) arm_q <= 1'b0;
        if (sclk_fall && (frame_low || rb_low)) begin
          sdo_q   <= shift_q[WORD_W-1];
          shift_q <= {shift_q[WORD_W-2:0], sdin};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (frame_start) cnt_q <= '0;
    else if (sclk_fall && frame_low && !full_o) cnt_q <= cnt_q + 1'b1;
  end

  assign shift_o = shift_q;
  assign sdo_o   = sdo_q;
endmodule

// File: rtl/sdac_update.sv
module sdac_update
  import sdac_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              frame_full,
  input  logic [WORD_W-1:0] word,
  input  logic              ldac_low,
  input  logic              clr_fall,
  input  logic              clr_high,
  output logic [CODE_W-1:0] dac_o,
  output logic              pend_o,
  output logic              defer_o,
  output logic              clear_o,
  output logic              commit_o
);
  logic [CODE_W-1:0]  dac_q, hold_q;
  logic               pend_q, defer_q, clear_q;
  logic [FIELD_W-1:0] code_full;
  logic               commit_imm, commit_late, park;

  assign code_full   = word_to_code(word, CODE_W);
  assign commit_imm  = frame_end & frame_full & ~defer_q;
  assign park        = frame_end & frame_full & defer_q;
  assign commit_late = pend_q & ldac_low & ~commit_imm;
  assign commit_o    = commit_imm | commit_late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) defer_q <= 1'b0;
    else if (frame_start) defer_q <= ~ldac_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (commit_imm) dac_q <= code_full[CODE_W-1:0];
      else if (commit_late) dac_q <= hold_q;
      if (park) begin
        pend_q <= 1'b1;
        hold_q <= code_full[CODE_W-1:0];
      end else if (commit_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clear_q <= 1'b0;
    else if (clr_fall) clear_q <= 1'b1;
    else if (clr_high && ldac_low) clear_q <= 1'b0;
  end

  assign dac_o   = dac_q;
  assign pend_o  = pend_q;
  assign defer_o = defer_q;
  assign clear_o = clear_q;
endmodule

// File: rtl/serdac_front.sv
module serdac_front
  import sdac_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdin_i,
  input  logic              load_n_i,
  input  logic              rdbk_n_i,
  input  logic              clr_n_i,
  input  logic              pwrdn_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              out_clear_o,
  output logic              pwrdn_o,
  output logic              sdo_pull_o
);
  localparam int NIN = 7;
  // bit order: pwrdn, clr, rdbk, load, sdin, frame, sclk
  localparam logic [NIN-1:0] IDLE = 7'b0111011;

  logic [NIN-1:0] lvl, fall, rise;
  logic [WORD_W-1:0] shift_w, rb_word;
  logic [CODE_W-1:0] dac_w;

  // named internal events
  logic ev_sclk_fall, ev_frame_start, ev_frame_end, ev_full;
  logic ev_rb_load, ev_commit, ev_clr_fall, st_pend, st_defer, sdo_bit;

  sdac_sync #(.W(NIN), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({pwrdn_i, clr_n_i, rdbk_n_i, load_n_i, sdin_i, frame_n_i, sclk_i}),
    .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
  );

  assign ev_sclk_fall   = fall[0];
  assign ev_frame_start = fall[1];
  assign ev_frame_end   = rise[1];
  assign ev_clr_fall    = fall[5];
  assign rb_word        = code_to_word(FIELD_W'(dac_w), CODE_W);

  sdac_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_fall(ev_sclk_fall), .frame_start(ev_frame_start),
    .frame_low(~lvl[1]), .rb_low(~lvl[4]), .rb_fall(fall[4]),
    .sdin(lvl[2]), .rb_word(rb_word),
    .shift_o(shift_w), .full_o(ev_full), .sdo_o(sdo_bit), .rb_load_o(ev_rb_load)
  );

  sdac_update #(.CODE_W(CODE_W)) u_upd (
    .clk(clk), .rst_n(rst_n),
    .frame_start(ev_frame_start), .frame_end(ev_frame_end), .frame_full(ev_full),
    .word(shift_w), .ldac_low(~lvl[3]),
    .clr_fall(ev_clr_fall), .clr_high(lvl[5]),
    .dac_o(dac_w), .pend_o(st_pend), .defer_o(st_defer),
    .clear_o(out_clear_o), .commit_o(ev_commit)
  );

  assign dac_code_o = dac_w;
  assign pwrdn_o    = lvl[6];
  assign sdo_pull_o = ~sdo_bit;
endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk #(
  parameter int CODE_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_code,
  input logic              commit,
  input logic              frame_end,
  input logic              full,
  input logic              pend,
  input logic              clr_fall,
  input logic              out_clear,
  input logic              sdo_pull,
  input logic              sclk_fall
);
  a_r4_code_moves_on_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(commit));

  a_r4_park_needs_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(frame_end && full));

  a_r5_short_frame_no_park: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !full) |=> !$rose(pend));

  a_r8_clear_follows_clr_fall: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> out_clear);

  a_r6_sdo_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_pull) |-> $past(sclk_fall));
endmodule

bind serdac_front serdac_front_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code_o), .commit(ev_commit),
  .frame_end(ev_frame_end), .full(ev_full), .pend(st_pend),
  .clr_fall(ev_clr_fall), .out_clear(out_clear_o), .sdo_pull(sdo_pull_o),
  .sclk_fall(ev_sclk_fall)
);

// File: tb/serdac_front_tb.sv
module serdac_front_tb;
  localparam int CW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, frame_n = 1'b1, sdin = 1'b0, load_n = 1'b1;
  logic rdbk_n = 1'b1, clr_n = 1'b1, pwrdn = 1'b0;
  logic [CW-1:0] dac_code;
  logic out_clear, pwrdn_o, sdo_pull;

  int n_checks = 0, n_fail = 0;
  logic done = 1'b0;
  logic [15:0] seen;

  always #2 clk = ~clk;

  serdac_front #(.CODE_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frame_n), .sdin_i(sdin),
    .load_n_i(load_n), .rdbk_n_i(rdbk_n), .clr_n_i(clr_n), .pwrdn_i(pwrdn),
    .dac_code_o(dac_code), .out_clear_o(out_clear), .pwrdn_o(pwrdn_o),
    .sdo_pull_o(sdo_pull)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one falling edge on sclk, then record the serial output (pull=1 -> bit 0)
  task automatic one_fall(input logic b, input int idx);
    sdin = b;
    sclk = 1'b1; wait_clk(6);
    sclk = 1'b0; wait_clk(6);
    if (idx >= 0) seen[idx] = ~sdo_pull;
    sclk = 1'b1;
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    frame_n = 1'b0; wait_clk(6);
    for (int k = 0; k < nbits; k++) one_fall(w[15-k], 15-k);
    wait_clk(6);
    frame_n = 1'b1; wait_clk(10);
  endtask

  task automatic t_reset;
    chk("R1 code", 32'(dac_code), 0);
    chk("R1 clear", 32'(out_clear), 0);
    chk("R1 pwrdn", 32'(pwrdn_o), 0);
    chk("R1 sdo released", 32'(sdo_pull), 0);
  endtask

  task automatic t_immediate;
    load_n = 1'b0; wait_clk(6);
    send(16'hD234, 16);
    chk("R2/R3 top bits ignored, loaded on frame end", 32'(dac_code), 32'h1234);
    send(16'h2ABC, 16);
    chk("R6 daisy chain delay of 16", 32'(seen), 32'hD234);
    chk("R3 second write", 32'(dac_code), 32'h2ABC);
  endtask

  task automatic t_deferred;
    load_n = 1'b1; wait_clk(6);
    send(16'h0F0F, 16);
    chk("R4 no load at frame end", 32'(dac_code), 32'h2ABC);
    load_n = 1'b0; wait_clk(10);
    chk("R4 load on strobe", 32'(dac_code), 32'h0F0F);
    load_n = 1'b1; wait_clk(6);
    send(16'h0001, 16);
    load_n = 1'b0; wait_clk(4);
    load_n = 1'b1; wait_clk(10);
    chk("R4 parked code loaded", 32'(dac_code), 32'h0001);
    load_n = 1'b0; wait_clk(10);
    chk("R4 repeat pulse no change", 32'(dac_code), 32'h0001);
  endtask

  task automatic t_short;
    load_n = 1'b0; wait_clk(6);
    send(16'h3333, 10);
    chk("R5 short frame dropped", 32'(dac_code), 32'h0001);
    load_n = 1'b1; wait_clk(6);
    send(16'h1555, 15);
    load_n = 1'b0; wait_clk(10);
    chk("R5 short frame not parked", 32'(dac_code), 32'h0001);
  endtask

  task automatic t_readback;
    load_n = 1'b0; wait_clk(6);
    send(16'hFFFF, 16);
    chk("R2 full scale", 32'(dac_code), 32'h3FFF);
    rdbk_n = 1'b0; wait_clk(8);
    for (int k = 0; k < 16; k++) one_fall(1'b1, 15 - k);
    rdbk_n = 1'b1; wait_clk(8);
    chk("R7 readback word", 32'(seen), 32'h3FFF);
    chk("R7 register kept", 32'(dac_code), 32'h3FFF);
    send(16'h0123, 16);
    rdbk_n = 1'b0; wait_clk(8);
    for (int k = 0; k < 16; k++) one_fall(1'b0, 15 - k);
    rdbk_n = 1'b1; wait_clk(8);
    chk("R7 readback second code", 32'(seen), 32'h0123);
  endtask

  task automatic t_clear;
    load_n = 1'b1; wait_clk(6);
    clr_n = 1'b0; wait_clk(8);
    chk("R8 clear set", 32'(out_clear), 1);
    chk("R8 register kept", 32'(dac_code), 32'h0123);
    clr_n = 1'b1; wait_clk(8);
    chk("R8 clear held without load", 32'(out_clear), 1);
    load_n = 1'b0; wait_clk(8);
    chk("R8 clear dropped by load", 32'(out_clear), 0);
    clr_n = 1'b0; wait_clk(8);
    chk("R8 clear set with load low", 32'(out_clear), 1);
    clr_n = 1'b1; wait_clk(8);
    chk("R8 auto restore", 32'(out_clear), 0);
    chk("R8 code restored", 32'(dac_code), 32'h0123);
  endtask

  task automatic t_pwrdn;
    pwrdn = 1'b1; wait_clk(6);
    chk("R9 flag set", 32'(pwrdn_o), 1);
    chk("R9 code kept", 32'(dac_code), 32'h0123);
    pwrdn = 1'b0; wait_clk(6);
    chk("R9 flag cleared", 32'(pwrdn_o), 0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_immediate;
    t_deferred;
    t_short;
    t_readback;
    t_clear;
    t_pwrdn;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule